// File: doc/BRIEF.md
# External Frame Lock Controller

This block keeps a video timing generator's internal frame aligned with an external sync source. It watches a separated external sync line and an external frame-reset line, both already synchronous to the tick clock. It classifies each sync pulse by its high width: short pulses are line sync and long ones carry vertical information. It then compares the external frame start with the internal field counter's frame start pulse.

In the two slow modes the block corrects phase gently. When the external frame start falls inside the internal frame, it sends a single add-line or drop-line request to the field counter. The direction depends on which half of the internal frame the error falls in. At most one request is issued per internal frame. In slow modes the vertical information may come either from a long pulse on the sync line or from a rising edge on the reset line, so separate horizontal and vertical signals are accepted. In fast mode, a rising edge on the reset line produces an immediate frame-reset pulse instead. In subcarrier mode all frame-lock activity is held idle.

Top module: `frame_lock_ctrl`

## Requirements
- R1: After synchronous reset every output is low.
- R2: When `ext_sync_i` goes low after being sampled high for more than VERT_TICKS (default 72) consecutive cycles, `vert_pulse_o` is high for one cycle in the cycle after the first low sample. A pulse of VERT_TICKS or fewer high samples gives `line_pulse_o` in the same position instead.
- R3: With `lock_mode` = 0 (subcarrier lock), all five outputs stay low.
- R4: In slow modes (`lock_mode` 1 or 2), an external frame start in the same cycle as `int_frame_start_i` (phase error zero) issues no request.
- R5: In slow modes, an external frame start at phase p (cycles since the last internal start) with 0 < 2p < P issues a one-cycle `add_line_o` in the next cycle. P is the measured internal frame period.
- R6: In slow modes, an external frame start with 2p >= P and p > 0 issues a one-cycle `drop_line_o` in the next cycle.
- R7: At most one add or drop request is issued between two consecutive internal frame starts; further external starts in that frame are ignored.
- R8: With `lock_mode` = 3 (fast), a rising edge of `ext_rst_i` gives a one-cycle `frame_reset_o` in the next cycle, and no add or drop request is ever issued. `frame_reset_o` is never high in other modes.
- R9: In slow modes, a rising edge of `ext_rst_i` counts as an external frame start, just like a vertical pulse on the sync line.
- R10: No request is issued until two internal frame starts have been seen since reset, because the period is unknown until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_mode | input | 2 | 0 subcarrier, 1 slow with external line reference, 2 slow with internal line reference, 3 fast |
| ext_sync_i | input | 1 | Separated external sync, or external horizontal pulse |
| ext_rst_i | input | 1 | External frame reset, or external vertical pulse |
| int_frame_start_i | input | 1 | One-cycle internal frame start from the field counter |
| line_pulse_o | output | 1 | Short external pulse recognized |
| vert_pulse_o | output | 1 | Long external pulse recognized |
| add_line_o | output | 1 | Request to lengthen the current frame by one line |
| drop_line_o | output | 1 | Request to shorten the current frame by one line |
| frame_reset_o | output | 1 | Immediate frame restart request (fast mode) |

## Verification
The bench targets the width threshold at exactly 72 and 73 high samples. A design with an off-by-one comparison would swap a line pulse for a vertical pulse there. It places external starts at phase zero, in the first half and in the second half of the frame. A sign error would lengthen a frame that should shrink, and a missing zero test would make needless corrections. It sends a second external start within one frame and an external start before the period is known; a design without the per-frame guard or the validity flag would issue extra requests. Random mode switching checks that subcarrier mode stays silent and that only fast mode produces frame resets.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;
  typedef enum logic [1:0] {
    LK_SUBCAR      = 2'd0,
    LK_SLOW_EXTREF = 2'd1,
    LK_SLOW_INTREF = 2'd2,
    LK_FAST        = 2'd3
  } lock_mode_e;
endpackage

// File: rtl/fl_pulse_sep.sv
module fl_pulse_sep #(
  parameter int VERT_TICKS = 72
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic vert_evt,
  output logic line_evt
);
  localparam int WCW = $clog2(VERT_TICKS + 2);
  localparam logic [WCW-1:0] WMAX = WCW'(VERT_TICKS + 1);
  localparam logic [WCW-1:0] WLIM = WCW'(VERT_TICKS);

  logic           sync_q;
  logic [WCW-1:0] wcnt;
  logic           fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      wcnt   <= '0;
    end else begin
      sync_q <= sync_in;
      if (!sync_in)          wcnt <= '0;
      else if (wcnt != WMAX) wcnt <= wcnt + 1'b1;
    end
  end

  assign fall     = sync_q & ~sync_in;
  assign vert_evt = fall & (wcnt > WLIM);
  assign line_evt = fall & ~(wcnt > WLIM);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    wcnt <= WMAX); // R2
endmodule

// File: rtl/fl_phase_track.sv
module fl_phase_track #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  output logic [PW-1:0] cur_phase,
  output logic [PW-1:0] period,
  output logic          per_valid
);
  localparam logic [PW-1:0] PMAX = '1;

  logic [PW-1:0] pos;
  logic          seen;

  assign cur_phase = frame_start ? '0 : pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      seen      <= 1'b0;
      period    <= '0;
      per_valid <= 1'b0;
    end else begin
      if (cur_phase != PMAX) pos <= cur_phase + 1'b1;
      if (frame_start) begin
        seen <= 1'b1;
        if (seen) begin
          period    <= pos;
          per_valid <= 1'b1;
        end
      end
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    per_valid |=> per_valid); // R10
endmodule

// File: rtl/frame_lock_ctrl.sv
module frame_lock_ctrl
  import frame_lock_pkg::*;
#(
  parameter int VERT_TICKS = 72,
  parameter int PW         = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lock_mode,
  input  logic       ext_sync_i,
  input  logic       ext_rst_i,
  input  logic       int_frame_start_i,
  output logic       line_pulse_o,
  output logic       vert_pulse_o,
  output logic       add_line_o,
  output logic       drop_line_o,
  output logic       frame_reset_o
);
  lock_mode_e    mode;
  logic          vert_evt, line_evt;
  logic          rst_q, rst_rise;
  logic [PW-1:0] cur_phase, period;
  logic          per_valid;
  logic          req_done;
  logic          slow, active, ext_start, want, early;

  assign mode = lock_mode_e'(lock_mode);

  fl_pulse_sep #(.VERT_TICKS(VERT_TICKS)) sep_i (
    .clk(clk), .rst(rst), .sync_in(ext_sync_i),
    .vert_evt(vert_evt), .line_evt(line_evt)
  );

  fl_phase_track #(.PW(PW)) trk_i (
    .clk(clk), .rst(rst), .frame_start(int_frame_start_i),
    .cur_phase(cur_phase), .period(period), .per_valid(per_valid)
  );

  assign rst_rise  = ext_rst_i & ~rst_q;
  assign slow      = (mode == LK_SLOW_EXTREF) || (mode == LK_SLOW_INTREF);
  assign active    = (mode != LK_SUBCAR);
  assign ext_start = slow & (vert_evt | rst_rise);
  assign want      = ext_start & per_valid & ~req_done & (cur_phase != '0);
  assign early     = {cur_phase, 1'b0} < {1'b0, period};

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q         <= 1'b0;
      req_done      <= 1'b0;
      line_pulse_o  <= 1'b0;
      vert_pulse_o  <= 1'b0;
      add_line_o    <= 1'b0;
      drop_line_o   <= 1'b0;
      frame_reset_o <= 1'b0;
    end else begin
      rst_q <= ext_rst_i;
      if (want)                   req_done <= 1'b1;
      else if (int_frame_start_i) req_done <= 1'b0;
      line_pulse_o  <= active & line_evt;
      vert_pulse_o  <= active & vert_evt;
      add_line_o    <= want & early;
      drop_line_o   <= want & ~early;
      frame_reset_o <= (mode == LK_FAST) & rst_rise;
    end
  end

  AST_IDLE_SUBCAR: assert property (@(posedge clk) disable iff (rst)
    (lock_mode == 2'd0) |=> !(add_line_o || drop_line_o || frame_reset_o || line_pulse_o || vert_pulse_o)); // R3
  AST_FAST_NO_ADJUST: assert property (@(posedge clk) disable iff (rst)
    (lock_mode == 2'd3) |=> !(add_line_o || drop_line_o)); // R8
  AST_RESET_ONLY_FAST: assert property (@(posedge clk) disable iff (rst)
    (lock_mode != 2'd3) |=> !frame_reset_o); // R8
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(add_line_o && drop_line_o)); // R5
  AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
    (add_line_o || drop_line_o) |=> !(add_line_o || drop_line_o)); // R7
  AST_VERT_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    vert_pulse_o |-> $past(!ext_sync_i)); // R2
endmodule

// File: tb/frame_lock_ctrl_tb_top.sv
module frame_lock_ctrl_tb_top;
  localparam int VT = 72;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] lock_mode;
  logic       ext_sync_i, ext_rst_i, int_frame_start_i;
  logic       line_pulse_o, vert_pulse_o, add_line_o, drop_line_o, frame_reset_o;

  frame_lock_ctrl #(.VERT_TICKS(VT), .PW(16)) dut_i (
    .clk(clk), .rst(rst), .lock_mode(lock_mode),
    .ext_sync_i(ext_sync_i), .ext_rst_i(ext_rst_i),
    .int_frame_start_i(int_frame_start_i),
    .line_pulse_o(line_pulse_o), .vert_pulse_o(vert_pulse_o),
    .add_line_o(add_line_o), .drop_line_o(drop_line_o),
    .frame_reset_o(frame_reset_o)
  );

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, ncyc = 0;
  string ctx = "";
  int flen = 200, fcnt = 0;
  int unsigned seed = 32'h1234abcd;

  // reference state, from the requirements
  bit m_sq, m_rq, m_seen, m_pv, m_done;
  int m_w, m_pos, m_per;

  task automatic chk(string tag, string what, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tg(string dflt);
    if (lock_mode == 2'd0) return "R3";
    if (ctx != "") return ctx;
    return dflt;
  endfunction

  task automatic cyc(input bit s, input bit r);
    bit f, fall, v, l, rise, slow, ext, want, e_add, e_drop;
    int cph;
    f = (fcnt == 0);
    ext_sync_i = s; ext_rst_i = r; int_frame_start_i = f;
    fall = m_sq && !s;
    v = fall && (m_w > VT);
    l = fall && !(m_w > VT);
    rise = r && !m_rq;
    cph = f ? 0 : m_pos;
    slow = (lock_mode == 2'd1) || (lock_mode == 2'd2);
    ext = slow && (v || rise);
    want = ext && m_pv && !m_done && (cph != 0);
    e_add = want && (2 * cph < m_per);
    e_drop = want && !(2 * cph < m_per);
    m_w = s ? ((m_w < VT + 1) ? m_w + 1 : m_w) : 0;
    m_sq = s; m_rq = r;
    if (f) begin
      if (m_seen) begin m_per = m_pos; m_pv = 1; end
      m_seen = 1;
    end
    m_pos = (cph < 65535) ? cph + 1 : cph;
    if (want) m_done = 1; else if (f) m_done = 0;
    fcnt = (fcnt + 1 >= flen) ? 0 : fcnt + 1;
    @(posedge clk); #1;
    ncyc++;
    chk(tg("R2"), "vert_pulse_o", vert_pulse_o, (lock_mode != 0) && v);
    chk(tg("R2"), "line_pulse_o", line_pulse_o, (lock_mode != 0) && l);
    chk(tg("R5"), "add_line_o", add_line_o, e_add);
    chk(tg("R6"), "drop_line_o", drop_line_o, e_drop);
    chk(tg("R8"), "frame_reset_o", frame_reset_o, (lock_mode == 2'd3) && rise);
  endtask

  task automatic seg(input int n, input int sf, input int st, input int rf, input int rt);
    for (int i = 0; i < n; i++) cyc(i >= sf && i < st, i >= rf && i < rt);
  endtask

  initial begin
    while (ncyc < 190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected<190000 cycles", ncyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst = 1'b1; lock_mode = 2'd2;
    ext_sync_i = 0; ext_rst_i = 0; int_frame_start_i = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "add_line_o", add_line_o, 1'b0);
    chk("R1", "drop_line_o", drop_line_o, 1'b0);
    chk("R1", "frame_reset_o", frame_reset_o, 1'b0);
    chk("R1", "vert_pulse_o", vert_pulse_o, 1'b0);
    chk("R1", "line_pulse_o", line_pulse_o, 1'b0);
    rst = 1'b0;
    m_sq = 0; m_rq = 0; m_seen = 0; m_pv = 0; m_done = 0; m_w = 0; m_pos = 0; m_per = 0;
    fcnt = 0; flen = 200;
    // directed corner cases, slow mode with internal line reference
    ctx = "R10"; seg(200, 0, 0, 50, 55);   // period unknown yet
    ctx = "R5";  seg(80, 0, 80, 0, 0);      // long sync pulse, fall at phase 80
    ctx = "R7";  seg(120, 0, 0, 40, 45);    // second start same frame, ignored
    ctx = "R9";  seg(200, 0, 0, 150, 155);  // reset input as vertical, late -> drop
    ctx = "R4";  seg(200, 0, 0, 0, 5);      // coincident start, no request
    ctx = "R2";  lock_mode = 2'd1;
    seg(200, 10, 82, 0, 0);                 // 72 high samples -> line
    seg(200, 10, 83, 0, 0);                 // 73 high samples -> vertical
    seg(200, 20, 23, 0, 0);                 // short line pulse
    ctx = "R8";  lock_mode = 2'd3;
    seg(200, 0, 90, 100, 104);              // fast: frame reset, no adjust
    ctx = "R3";  lock_mode = 2'd0;
    seg(200, 0, 90, 100, 104);
    ctx = "";
    // constrained random
    for (int k = 0; k < 40; k++) begin
      int left, sw, gap;
      lock_mode = 2'($urandom(seed) % 4);
      seed = seed + 17;
      flen = 300 + ($urandom() % 600);
      fcnt = fcnt % flen;
      left = 1200 + ($urandom() % 600);
      while (left > 0) begin
        sw = ($urandom() % 4 == 0) ? 60 + ($urandom() % 40) : 1 + ($urandom() % 20);
        gap = 5 + ($urandom() % 200);
        for (int i = 0; i < sw; i++) cyc(1'b1, ($urandom() % 64) < 3);
        for (int i = 0; i < gap; i++) cyc(1'b0, ($urandom() % 64) < 3);
        left = left - sw - gap;
      end
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule